// File: doc/BRIEF.md
# Eager Writeback Tag Controller

This block holds the tag, valid, dirty and recency state of a small four-way set-associative write-back cache. It answers each processor access with a hit or a miss, sends miss requests to the next level, and sends castouts to a writeback buffer. The data arrays live elsewhere. Only the block address and the kind of each writeback leave this block.

The block cleans a dirty line early: it writes the line back as soon as an access pushes it into the least-recently-used slot of its set, without waiting for the line to be evicted. The early writeback happens only on pages of the eager memory type. This moves writeback traffic off the cycles where demand misses need the bus. The line stays valid but becomes clean, so a later eviction costs nothing.

When the buffer is full, or when its single push port is taken that cycle, the set number goes into a short queue. Each free pulse from the buffer lets the controller retry the oldest queued set. A retry checks again whether that set's current LRU line is still valid and dirty.

Top module: `eager_wb_ctrl`

## Requirements
- R1: Each set has four ways ranked 0 (MRU) to 3 (LRU). After reset way w has rank w. An access promotes its way to rank 0, and every way that was more recent than it ages by one. A miss fills the way of rank 3.
- R2: `acc_hit`/`acc_miss` are registered and show the result of the access presented on the previous clock edge. A block address is {tag, set}, with the set in the low bits just above the 4 offset bits.
- R3: A write sets the dirty bit of the accessed line. A miss whose LRU victim is valid and dirty pushes the victim's block address with `wbb_eager`=0 one cycle later, whatever the level of `wbb_full`.
- R4: On an eager-page access to the LRU way (a hit on it, or a miss), if the way of rank 2 is valid and dirty, the controller pushes that way's block address with `wbb_eager`=1. It does this only when `wbb_full` is low and no castout is pushed. The pushed line stays valid and becomes clean.
- R5: A miss whose victim was cleaned early replaces it with no push.
- R6: An access on a page that is not of the eager type never causes an early push.
- R7: An early writeback that cannot be pushed stores its set number in the queue (depth 4). A set that is already queued is not stored again, and a request that arrives while the queue is full is dropped.
- R8: A free pulse arms a retry. In each later cycle the retry pops the oldest queued set, provided the push port is idle, `wbb_full` is low, and the access that cycle is to a different set. If that set's LRU way is valid and dirty, the retry pushes it with `wbb_eager`=1 and uses up the armed retry. Otherwise it drops the entry and stays armed.
- R9: A demand miss always raises `nl_req` with its block address on the cycle after the access. A castout takes the push port ahead of an early writeback.
- R10: After reset every line is invalid and clean, the queue is empty and all outputs are low.
- R11: A write hit on a clean line makes it dirty again, so the line can be written back early again when it next reaches rank 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| acc_valid | input | 1 | processor access this cycle |
| acc_addr | input | ADDR_W | byte address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_eager_page | input | 1 | page memory type is the eager write-back type |
| acc_hit | output | 1 | previous access hit |
| acc_miss | output | 1 | previous access missed |
| nl_req | output | 1 | next-level fill request |
| nl_addr | output | ADDR_W-OFFSET_W | block address of the fill |
| wbb_full | input | 1 | writeback buffer cannot take an early line |
| wbb_free | input | 1 | pulse: buffer released an entry |
| wbb_push | output | 1 | line pushed into writeback buffer |
| wbb_addr | output | ADDR_W-OFFSET_W | block address of the pushed line |
| wbb_eager | output | 1 | push is an early cleaning, not a castout |

## Verification
The bench runs directed sequences, then a long pseudo-random stream over six tags per set, against a cycle model built from the requirements.

It targets the trigger on an LRU hit and on a miss fill. A design that watched the wrong rank would clean the line being accessed instead of the one that just aged into rank 3.

It checks that a victim already cleaned early leaves without a push. A design that forgot to clear the dirty bit would write the same block twice.

It drives a full buffer during early pushes, then sends free pulses. This exposes duplicate queue entries, lost retries, and retries that push lines which have since been cleaned or replaced.

Finally, it runs misses with dirty victims while triggers are pending. A design with the wrong port priority would delay a castout or swallow a miss request.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAYS-1:0][WAY_W-1:0] set_rank_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CASTOUT,
        SRC_TRIGGER,
        SRC_RETRY
    } push_src_e;

    function automatic way_t rank_find(set_rank_t r, way_t k);
        way_t f;
        f = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (r[w] == k) f = way_t'(w);
        end
        return f;
    endfunction

endpackage

// File: rtl/ewb_lru_bank.sv
module ewb_lru_bank
    import ewb_pkg::*;
#(
    parameter int SETS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    touch,
    input  logic [$clog2(SETS)-1:0] touch_set,
    input  way_t                    touch_way,
    output set_rank_t [SETS-1:0]    rank_o
);

    localparam int SET_W = $clog2(SETS);

    set_rank_t [SETS-1:0] rank_q;
    set_rank_t            upd;

    always_comb begin
        upd = rank_q[touch_set];
        for (int w = 0; w < WAYS; w++) begin
            if (way_t'(w) == touch_way)
                upd[w] = '0;
            else if (rank_q[touch_set][w] < rank_q[touch_set][touch_way])
                upd[w] = rank_q[touch_set][w] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= way_t'(w);
        end else if (touch) begin
            rank_q[touch_set] <= upd;
        end
    end

    assign rank_o = rank_q;

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        logic [WAYS-1:0] is_lru, is_mru;
        always_comb begin
            for (int w = 0; w < WAYS; w++) begin
                is_lru[w] = (rank_q[s][w] == way_t'(WAYS - 1));
                is_mru[w] = (rank_q[s][w] == '0);
            end
        end
        AST_LRU_UNIQUE: assert property (@(posedge clk) disable iff (rst)
            $onehot(is_lru) && $onehot(is_mru)); // R1
    end

    logic unused_w;
    assign unused_w = ^SET_W;

endmodule

// File: rtl/ewb_set_queue.sv
module ewb_set_queue #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    input  logic [ID_W-1:0] query_id,
    output logic            query_hit,
    output logic [ID_W-1:0] head_o,
    output logic            empty_o,
    output logic            full_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0] ent_q [DEPTH];
    logic [ID_W-1:0] ent_d [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        ent_d = ent_q;
        cnt_d = cnt_q;
        if (pop && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i + 1];
            cnt_d = cnt_q - 1'b1;
        end
        if (push && cnt_d < CNT_W'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_d) ent_d[i] = push_id;
            cnt_d = cnt_d + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            ent_q <= ent_d;
        end
    end

    always_comb begin
        query_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (CNT_W'(i) < cnt_q && ent_q[i] == query_id) query_hit = 1'b1;
    end

    assign head_o  = ent_q[0];
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));

    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
                if (CNT_W'(j) < cnt_q && ent_q[i] == ent_q[j]) dup = 1'b1;
    end

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)); // R7
    AST_Q_NO_DUP: assert property (@(posedge clk) disable iff (rst)
        !dup); // R7
    AST_Q_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty_o); // R8

endmodule

// File: rtl/eager_wb_ctrl.sv
module eager_wb_ctrl
    import ewb_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFFSET_W = 4,
    parameter int SETS     = 4,
    parameter int EQ_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_valid,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic                       acc_write,
    input  logic                       acc_eager_page,
    output logic                       acc_hit,
    output logic                       acc_miss,
    output logic                       nl_req,
    output logic [ADDR_W-OFFSET_W-1:0] nl_addr,
    input  logic                       wbb_full,
    input  logic                       wbb_free,
    output logic                       wbb_push,
    output logic [ADDR_W-OFFSET_W-1:0] wbb_addr,
    output logic                       wbb_eager
);

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFFSET_W - SET_W;
    localparam int BLK_W = ADDR_W - OFFSET_W;
    localparam way_t LRU_RANK = way_t'(WAYS - 1);
    localparam way_t SEC_RANK = way_t'(WAYS - 2);

    logic [TAG_W-1:0]            tag_q [SETS][WAYS];
    logic [SETS-1:0][WAYS-1:0]   valid_q, dirty_q;

    logic [SET_W-1:0] a_set;
    logic [TAG_W-1:0] a_tag;
    assign a_set = acc_addr[OFFSET_W +: SET_W];
    assign a_tag = acc_addr[ADDR_W-1 -: TAG_W];

    // recency
    set_rank_t [SETS-1:0] rank_w;
    way_t lru_a, sec_a, hit_way, acc_way;
    logic [WAYS-1:0] hit_vec;
    logic hit_any;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[a_set][w] && (tag_q[a_set][w] == a_tag);
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end

    assign hit_any = |hit_vec;
    assign lru_a   = rank_find(rank_w[a_set], LRU_RANK);
    assign sec_a   = rank_find(rank_w[a_set], SEC_RANK);
    assign acc_way = hit_any ? hit_way : lru_a;

    ewb_lru_bank #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch     (acc_valid),
        .touch_set (a_set),
        .touch_way (acc_way),
        .rank_o    (rank_w)
    );

    // writeback sources
    logic castout, trig, trig_push, trig_enq;
    assign castout   = acc_valid && !hit_any && valid_q[a_set][lru_a] && dirty_q[a_set][lru_a];
    assign trig      = acc_valid && acc_eager_page && (acc_way == lru_a)
                       && valid_q[a_set][sec_a] && dirty_q[a_set][sec_a];
    assign trig_push = trig && !castout && !wbb_full;

    // pending-set queue and retry
    logic             q_hit, q_empty, q_full, q_pop;
    logic [SET_W-1:0] q_head;
    logic             pend_q;
    logic             retry_go, retry_push;
    way_t             r_way;

    assign trig_enq = trig && !trig_push && !q_full && !q_hit;

    ewb_set_queue #(.DEPTH(EQ_DEPTH), .ID_W(SET_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (trig_enq),
        .push_id   (a_set),
        .pop       (q_pop),
        .query_id  (a_set),
        .query_hit (q_hit),
        .head_o    (q_head),
        .empty_o   (q_empty),
        .full_o    (q_full)
    );

    assign r_way      = rank_find(rank_w[q_head], LRU_RANK);
    assign retry_go   = pend_q && !q_empty && !castout && !trig && !wbb_full
                        && !(acc_valid && a_set == q_head);
    assign retry_push = retry_go && valid_q[q_head][r_way] && dirty_q[q_head][r_way];
    assign q_pop      = retry_go;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= wbb_free || (pend_q && !retry_push && !q_empty);
    end

    // push port arbitration: castout, then trigger, then retry
    push_src_e        src;
    logic [BLK_W-1:0] push_addr;

    always_comb begin
        src       = SRC_NONE;
        push_addr = '0;
        if (castout) begin
            src       = SRC_CASTOUT;
            push_addr = {tag_q[a_set][lru_a], a_set};
        end else if (trig_push) begin
            src       = SRC_TRIGGER;
            push_addr = {tag_q[a_set][sec_a], a_set};
        end else if (retry_push) begin
            src       = SRC_RETRY;
            push_addr = {tag_q[q_head][r_way], q_head};
        end
    end

    // line state
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    tag_q[s][w] <= '0;
        end else begin
            if (retry_push) dirty_q[q_head][r_way] <= 1'b0;
            if (trig_push)  dirty_q[a_set][sec_a]  <= 1'b0;
            if (acc_valid) begin
                if (hit_any) begin
                    dirty_q[a_set][hit_way] <= dirty_q[a_set][hit_way] | acc_write;
                end else begin
                    tag_q[a_set][lru_a]   <= a_tag;
                    valid_q[a_set][lru_a] <= 1'b1;
                    dirty_q[a_set][lru_a] <= acc_write;
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hit   <= 1'b0;
            acc_miss  <= 1'b0;
            nl_req    <= 1'b0;
            nl_addr   <= '0;
            wbb_push  <= 1'b0;
            wbb_addr  <= '0;
            wbb_eager <= 1'b0;
        end else begin
            acc_hit   <= acc_valid && hit_any;
            acc_miss  <= acc_valid && !hit_any;
            nl_req    <= acc_valid && !hit_any;
            nl_addr   <= {a_tag, a_set};
            wbb_push  <= (src != SRC_NONE);
            wbb_addr  <= push_addr;
            wbb_eager <= (src == SRC_TRIGGER) || (src == SRC_RETRY);
        end
    end

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(acc_hit && acc_miss)); // R2
    AST_MISS_REQ: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !hit_any) |=> (nl_req && acc_miss)); // R9
    AST_CASTOUT_FIRST: assert property (@(posedge clk) disable iff (rst)
        castout |=> (wbb_push && !wbb_eager)); // R3
    AST_EAGER_ROOM: assert property (@(posedge clk) disable iff (rst)
        trig_push |=> (wbb_push && wbb_eager)); // R4
    AST_PLAIN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_eager_page && !retry_push) |=> !(wbb_push && wbb_eager)); // R6

endmodule

// File: tb/eager_wb_ctrl_test.sv
module eager_wb_ctrl_test;

    localparam int ADDR_W = 12;
    localparam int BLK_W  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, acc_valid, acc_write, acc_eager_page, wbb_full, wbb_free;
    logic [ADDR_W-1:0] acc_addr;
    logic acc_hit, acc_miss, nl_req, wbb_push, wbb_eager;
    logic [BLK_W-1:0] nl_addr, wbb_addr;

    eager_wb_ctrl uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_eager_page(acc_eager_page),
        .acc_hit(acc_hit), .acc_miss(acc_miss), .nl_req(nl_req), .nl_addr(nl_addr),
        .wbb_full(wbb_full), .wbb_free(wbb_free), .wbb_push(wbb_push),
        .wbb_addr(wbb_addr), .wbb_eager(wbb_eager)
    );

    int vecs = 0, errs = 0, ncyc = 0;

    // model state
    int m_tag [4][4];
    bit m_val [4][4];
    bit m_dty [4][4];
    int m_rank[4][4];
    int m_q[4];
    int m_qn;
    bit m_pend;

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    function automatic int find_rank(int s, int r);
        for (int w = 0; w < 4; w++) if (m_rank[s][w] == r) return w;
        return 0;
    endfunction

    task automatic chk(string lab, string fld, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d", lab, fld, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                m_tag[s][w] = 0; m_val[s][w] = 0; m_dty[s][w] = 0; m_rank[s][w] = w;
            end
        m_qn = 0; m_pend = 0;
    endtask

    task automatic cyc(string lab, bit v, int tg, int st, bit wr, bit eg, bit full, bit fr);
        int hw, lw, sw, aw, hd, rw, r0, e_addr;
        bit hit, co, tr, tp, te, rg, rp, inq, e_push, e_eag;
        hit = 0; hw = 0;
        for (int w = 0; w < 4; w++)
            if (m_val[st][w] && m_tag[st][w] == tg) begin hit = 1; hw = w; end
        lw = find_rank(st, 3);
        sw = find_rank(st, 2);
        aw = hit ? hw : lw;
        co = v && !hit && m_val[st][lw] && m_dty[st][lw];
        tr = v && eg && aw == lw && m_val[st][sw] && m_dty[st][sw];
        tp = tr && !co && !full;
        inq = 0;
        for (int i = 0; i < m_qn; i++) if (m_q[i] == st) inq = 1;
        te = tr && !tp && m_qn < 4 && !inq;
        hd = m_q[0];
        rw = find_rank(hd, 3);
        rg = m_pend && m_qn > 0 && !co && !tr && !full && !(v && st == hd);
        rp = rg && m_val[hd][rw] && m_dty[hd][rw];
        e_push = co || tp || rp;
        e_eag  = !co && (tp || rp);
        e_addr = co ? (m_tag[st][lw] * 4 + st) : tp ? (m_tag[st][sw] * 4 + st)
                                               : (m_tag[hd][rw] * 4 + hd);
        // drive
        acc_valid = v; acc_addr = ADDR_W'(tg * 64 + st * 16 + 5);
        acc_write = wr; acc_eager_page = eg; wbb_full = full; wbb_free = fr;
        // model update
        m_pend = fr || (m_pend && !rp && m_qn > 0);
        if (rg) begin
            for (int i = 0; i < 3; i++) m_q[i] = m_q[i + 1];
            m_qn--;
        end
        if (te) begin m_q[m_qn] = st; m_qn++; end
        if (rp) m_dty[hd][rw] = 0;
        if (tp) m_dty[st][sw] = 0;
        if (v) begin
            if (hit) m_dty[st][hw] = m_dty[st][hw] | wr;
            else begin m_tag[st][lw] = tg; m_val[st][lw] = 1; m_dty[st][lw] = wr; end
            r0 = m_rank[st][aw];
            for (int w = 0; w < 4; w++)
                if (w == aw) m_rank[st][w] = 0;
                else if (m_rank[st][w] < r0) m_rank[st][w]++;
        end
        @(posedge clk);
        @(negedge clk);
        chk(lab, "acc_hit", acc_hit, v && hit);
        chk(lab, "acc_miss", acc_miss, v && !hit);
        chk(lab, "nl_req", nl_req, v && !hit);
        if (v && !hit) chk(lab, "nl_addr", nl_addr, tg * 4 + st);
        chk(lab, "wbb_push", wbb_push, e_push);
        if (e_push) begin
            chk(lab, "wbb_addr", wbb_addr, e_addr);
            chk(lab, "wbb_eager", wbb_eager, e_eag);
        end
        acc_valid = 0; wbb_free = 0;
    endtask

    task automatic idle(string lab, bit full, bit fr);
        cyc(lab, 0, 0, 0, 0, 0, full, fr);
    endtask

    int lfsr = 32'h1ace_b00c;
    function automatic int rnd();
        lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04c1_1db7 : 0);
        return lfsr & 32'h7fff_ffff;
    endfunction

    initial begin
        rst = 1; acc_valid = 0; acc_addr = '0; acc_write = 0; acc_eager_page = 0;
        wbb_full = 0; wbb_free = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R10: reset state
        chk("R10", "acc_hit", acc_hit, 0);
        chk("R10", "acc_miss", acc_miss, 0);
        chk("R10", "nl_req", nl_req, 0);
        chk("R10", "wbb_push", wbb_push, 0);
        for (int s = 0; s < 4; s++) cyc("R10", 1, 0, s, 0, 0, 0, 0);

        // R1/R2: fill set 0 with loads, hit, evict by rank
        for (int t = 1; t <= 4; t++) cyc("R1", 1, t, 0, 0, 0, 0, 0);
        cyc("R2", 1, 1, 0, 0, 0, 0, 0);
        cyc("R1", 1, 5, 0, 0, 0, 0, 0);
        cyc("R1", 1, 2, 0, 0, 0, 0, 0);

        // R3: dirty castout ignores full
        for (int t = 1; t <= 4; t++) cyc("R3", 1, t, 2, 1, 0, 0, 0);
        cyc("R3", 1, 9, 2, 1, 0, 1, 0);
        cyc("R9", 1, 10, 2, 0, 1, 0, 0);

        // R4/R5/R11: eager page fills set 3
        for (int t = 1; t <= 4; t++) cyc("R4", 1, t, 3, 1, 1, 0, 0);
        cyc("R4", 1, 1, 3, 0, 1, 0, 0);
        cyc("R4", 1, 2, 3, 0, 1, 0, 0);
        cyc("R5", 1, 11, 3, 0, 0, 0, 0);
        cyc("R11", 1, 4, 3, 1, 1, 0, 0);
        cyc("R11", 1, 1, 3, 0, 1, 0, 0);
        cyc("R11", 1, 11, 3, 0, 1, 0, 0);
        cyc("R11", 1, 3, 3, 0, 1, 0, 0);

        // R6: same pattern on plain pages
        for (int t = 20; t <= 25; t++) cyc("R6", 1, t % 64, 1, 1, 0, 0, 0);

        // R7/R8: queue under full buffer, then free pulses
        for (int s = 0; s < 4; s++)
            for (int t = 30; t <= 34; t++) cyc("R7", 1, t, s, 1, 1, 1, 0);
        cyc("R7", 1, 40, 1, 1, 1, 1, 0);
        for (int k = 0; k < 6; k++) begin
            idle("R8", 0, 1);
            idle("R8", 0, 0);
        end
        cyc("R8", 1, 30, 2, 1, 1, 1, 0);
        idle("R8", 0, 1);
        cyc("R8", 1, 31, 0, 0, 1, 0, 0);
        idle("R8", 0, 0);

        // near-exhaustive random sweep
        for (int n = 0; n < 6000; n++) begin
            int r;
            r = rnd();
            cyc("R9", (r & 3) != 0, (r >> 2) % 6, (r >> 5) & 3, ((r >> 7) & 1) != 0,
                ((r >> 8) & 3) != 0, ((r >> 10) & 3) == 0, ((r >> 12) & 7) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule